// File: doc/BRIEF.md
# Writeback Commit Stage with Jump Redirect

This block is the last stage of an in-order pipeline. Each cycle it may accept one retiring instruction and decides what that instruction leaves behind. It can write a result into a register file that is split into scalar registers and vector registers. It can move the program counter on to the next instruction. Or it can redirect the program counter to a jump target and flush everything younger.

The destination register does not come from the instruction record. It is taken from the head of a small first-in first-out queue of register indices, which the issue side fills when it reserves a destination. One index space covers both files: the low indices name scalar registers and the indices just above them name vector registers.

A jump instruction is taken when the value it carries is strictly positive. A taken jump loads the program counter from that value, empties the reservation queue and pulses a squash to the earlier stages. A taken jump-and-link also writes the return address into scalar register 1. Misuse of the queue sets an error flag that freezes all further commit effects until reset.

Top module: `wb_commit`

## Requirements
- R1: After reset, `pc` equals `RESET_PC`, `err` is 0, the reservation queue is empty, and `gpr_we`, `vr_we`, `squash` and `sb_clear` are 0.
- R2: A valid record whose kind is 1 (no-operation), or whose format is 0 (invalid), causes no write, no squash and no queue pop, and leaves `pc` unchanged.
- R3: A register write is attempted only for format 1 or 2 records whose kind is not 2. A kind-2 record (store) pops nothing and writes nothing.
- R4: The destination of each write is the oldest queued index. Entries leave in push order. A push and a pop in the same cycle are both honoured.
- R5: Destination handling depends on the popped index:
  - An index below `GPR_NUM` drives the scalar port in the same cycle, with that address and `ret_value` as data. Register 0 is written like any other register.
  - An index from `GPR_NUM` to `GPR_NUM+VEC_NUM-1` drives the vector port instead, with address index minus `GPR_NUM` and `ret_vdata` as data.
- R6: These are error cases:
  - A write-type record that finds the queue empty writes nothing, and `err` reads 1 from the next cycle on.
  - A write-type record whose popped index is `GPR_NUM+VEC_NUM` or more writes nothing, and `err` reads 1 from the next cycle on.
  - Once `err` is 1 it stays 1 until reset. While it is 1 there are no register writes and no squash, and `pc` holds.
- R7: A format 3 (jump) record is taken only when `ret_value`, read as signed, is greater than zero.
  - When taken, `squash` and `sb_clear` pulse in that cycle, and `pc` equals the low `PC_W` bits of `ret_value` in the next cycle.
  - A taken jump empties the queue, and a push in that same cycle is dropped.
  - A value of 0 or less is not taken.
- R8: A taken jump of kind 3 (jump-and-link) writes scalar register 1 in the same cycle with the current `pc` plus one.
- R9: Every valid record that is not a no-operation, has a valid format and is not a taken jump advances `pc` by one, wrapping modulo 2^`PC_W`.
- R10: A push into a full queue, in a cycle with no pop, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | A record retires this cycle |
| ret_kind | input | 2 | 0 plain, 1 no-operation, 2 store, 3 jump-and-link |
| ret_fmt | input | 2 | 0 invalid, 1 register form, 2 immediate form, 3 jump form |
| ret_value | input | 32 | Scalar result or jump target (signed) |
| ret_vdata | input | VEC_W | Vector result word |
| sb_push | input | 1 | Reserve a destination index |
| sb_push_idx | input | IDX_W | Index being reserved |
| gpr_we | output | 1 | Scalar register write enable |
| gpr_waddr | output | GA_W | Scalar register address |
| gpr_wdata | output | 32 | Scalar write data |
| vr_we | output | 1 | Vector register write enable |
| vr_waddr | output | VA_W | Vector register address |
| vr_wdata | output | VEC_W | Vector write data |
| pc | output | PC_W | Program counter |
| squash | output | 1 | Flush pulse to earlier stages |
| sb_clear | output | 1 | Reservation wipe pulse |
| err | output | 1 | Sticky commit error |

## Verification
The assertions take for granted that `ret_kind` and `ret_fmt` only carry the four listed codes. They also assume that a jump-and-link record always arrives with the jump format. The stimulus keeps to this: it uses jump-and-link only with format 3 and uses store only with the register and immediate formats.

Beyond that, the bench relies on the design's own error path rather than avoiding bad inputs. It pops an empty queue and queues indices up to the top of the index width on purpose, and it resets after each such case so that later sweeps start from a clean, error-free state.

// File: rtl/wb_commit.sv
module wb_commit #(
  parameter int GPR_NUM  = 8,
  parameter int VEC_NUM  = 4,
  parameter int VEC_W    = 64,
  parameter int SB_DEPTH = 8,
  parameter int PC_W     = 32,
  parameter int RESET_PC = 0,
  parameter int IDX_W    = $clog2(GPR_NUM + VEC_NUM) + 1,
  parameter int GA_W     = $clog2(GPR_NUM > 1 ? GPR_NUM : 2),
  parameter int VA_W     = $clog2(VEC_NUM > 1 ? VEC_NUM : 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid,
  input  logic [1:0]       ret_kind,
  input  logic [1:0]       ret_fmt,
  input  logic [31:0]      ret_value,
  input  logic [VEC_W-1:0] ret_vdata,
  input  logic             sb_push,
  input  logic [IDX_W-1:0] sb_push_idx,
  output logic             gpr_we,
  output logic [GA_W-1:0]  gpr_waddr,
  output logic [31:0]      gpr_wdata,
  output logic             vr_we,
  output logic [VA_W-1:0]  vr_waddr,
  output logic [VEC_W-1:0] vr_wdata,
  output logic [PC_W-1:0]  pc,
  output logic             squash,
  output logic             sb_clear,
  output logic             err
);
  localparam int PTR_W = $clog2(SB_DEPTH > 1 ? SB_DEPTH : 2);
  localparam int CNT_W = $clog2(SB_DEPTH + 1);
  localparam logic [1:0] K_NOP = 2'd1, K_STORE = 2'd2, K_JAL = 2'd3;
  localparam logic [1:0] F_INV = 2'd0, F_R = 2'd1, F_I = 2'd2, F_J = 2'd3;
  localparam logic [IDX_W-1:0] N_GPR = IDX_W'(GPR_NUM);
  localparam logic [IDX_W-1:0] N_ALL = IDX_W'(GPR_NUM + VEC_NUM);

  logic [IDX_W-1:0] q_mem [SB_DEPTH];
  logic [PTR_W-1:0] rd_p, wr_p;
  logic [CNT_W-1:0] cnt;
  logic [PC_W-1:0]  pc_q;
  logic             err_q;

  logic live, is_wr, taken, q_empty, pop, push_ok;
  logic [IDX_W-1:0] head;

  assign live    = ret_valid && !err_q && ret_kind != K_NOP && ret_fmt != F_INV;
  assign is_wr   = live && (ret_fmt == F_R || ret_fmt == F_I) && ret_kind != K_STORE;
  assign taken   = live && ret_fmt == F_J && $signed(ret_value) > 0;
  assign q_empty = (cnt == '0);
  assign pop     = is_wr && !q_empty;
  assign head    = q_mem[rd_p];
  assign push_ok = sb_push && !taken && (cnt != CNT_W'(SB_DEPTH) || pop);

  assign gpr_we    = (pop && head < N_GPR) || (taken && ret_kind == K_JAL);
  assign gpr_waddr = taken ? GA_W'(1) : head[GA_W-1:0];
  assign gpr_wdata = taken ? 32'(PC_W'(pc_q + 1'b1)) : ret_value;
  assign vr_we     = pop && head >= N_GPR && head < N_ALL;
  assign vr_waddr  = VA_W'(head - N_GPR);
  assign vr_wdata  = ret_vdata;
  assign squash    = taken;
  assign sb_clear  = taken;
  assign pc        = pc_q;
  assign err       = err_q;

  always_ff @(posedge clk)
    if (push_ok) q_mem[wr_p] <= sb_push_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p  <= '0;
      wr_p  <= '0;
      cnt   <= '0;
      pc_q  <= PC_W'(RESET_PC);
      err_q <= 1'b0;
    end else begin
      err_q <= err_q || (is_wr && (q_empty || head >= N_ALL));
      if (taken) pc_q <= PC_W'(ret_value);
      else if (live) pc_q <= pc_q + 1'b1;
      if (taken) begin
        rd_p <= '0;
        wr_p <= '0;
        cnt  <= '0;
      end else begin
        if (push_ok) wr_p <= (wr_p == PTR_W'(SB_DEPTH - 1)) ? '0 : wr_p + 1'b1;
        if (pop)     rd_p <= (rd_p == PTR_W'(SB_DEPTH - 1)) ? '0 : rd_p + 1'b1;
        cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop);
      end
    end
  end

  AST_QUIET_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && (ret_kind == K_NOP || ret_fmt == F_INV) |-> !gpr_we && !vr_we && !squash); // R2
  AST_NOP_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && (ret_kind == K_NOP || ret_fmt == F_INV) |=> pc == $past(pc)); // R2
  AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && ret_kind == K_STORE |-> !gpr_we && !vr_we); // R3
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(gpr_we && vr_we)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R6
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !gpr_we && !vr_we && !squash); // R6
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> pc == $past(PC_W'(ret_value))); // R7
  AST_JAL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    squash && ret_kind == K_JAL |-> gpr_we && gpr_waddr == GA_W'(1)); // R8
endmodule

// File: tb/wb_commit_tb_top.sv
`timescale 1ns/1ps
module wb_commit_tb_top;
  localparam int VW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic v = 1'b0, p = 1'b0;
  logic [1:0] k = 2'd0, f = 2'd0;
  logic [31:0] val = '0;
  logic [VW-1:0] vd = '0;
  logic [4:0] pi = '0;
  logic gpr_we, vr_we, squash, sb_clear, err;
  logic [2:0] gpr_waddr;
  logic [1:0] vr_waddr;
  logic [31:0] gpr_wdata;
  logic [VW-1:0] vr_wdata;
  logic [7:0] pc;
  int checks = 0, errors = 0;
  int exp_pc;

  localparam logic [1:0] PL = 2'd0, NP = 2'd1, ST = 2'd2, JL = 2'd3;
  localparam logic [1:0] FI = 2'd0, FR = 2'd1, FM = 2'd2, FJ = 2'd3;

  always #2 clk = ~clk;

  wb_commit #(.GPR_NUM(8), .VEC_NUM(4), .VEC_W(VW), .SB_DEPTH(4), .PC_W(8), .RESET_PC(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .ret_valid(v), .ret_kind(k), .ret_fmt(f), .ret_value(val),
    .ret_vdata(vd), .sb_push(p), .sb_push_idx(pi), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr),
    .gpr_wdata(gpr_wdata), .vr_we(vr_we), .vr_waddr(vr_waddr), .vr_wdata(vr_wdata),
    .pc(pc), .squash(squash), .sb_clear(sb_clear), .err(err));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic vv, input logic [1:0] kk, input logic [1:0] ff,
                       input logic [31:0] vl, input logic [VW-1:0] vdd,
                       input logic pp, input logic [4:0] pidx);
    @(negedge clk);
    v = vv; k = kk; f = ff; val = vl; vd = vdd; p = pp; pi = pidx;
    #1;
  endtask

  task automatic idle(); drive(1'b0, PL, FI, 0, 0, 1'b0, 5'd0); endtask
  task automatic push(input int idx); drive(1'b0, PL, FI, 0, 0, 1'b1, 5'(idx)); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; v = 1'b0; p = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_pc = 16;
    #1;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 pc", pc, 16);
    chk("R1 err", err, 0);
    chk("R1 writes", gpr_we | vr_we, 0);
    chk("R1 squash", squash | sb_clear, 0);

    for (int i = 0; i < 12; i++) begin
      push(i);
      drive(1'b1, PL, FR, 100 + i, VW'(i * 3 + 1), 1'b0, 5'd0);
      if (i < 8) begin
        chk("R5 scalar we", gpr_we, 1);
        chk("R5 scalar addr", gpr_waddr, i);
        chk("R5 scalar data", gpr_wdata, 100 + i);
        chk("R5 no vector", vr_we, 0);
      end else begin
        chk("R5 vector we", vr_we, 1);
        chk("R5 vector addr", vr_waddr, i - 8);
        chk("R5 vector data", vr_wdata, i * 3 + 1);
        chk("R5 no scalar", gpr_we, 0);
      end
      exp_pc++;
    end
    idle();
    chk("R9 pc after sweep", pc, exp_pc);

    push(3); push(9); push(5);
    drive(1'b1, PL, FM, 11, 0, 1'b1, 5'd2);
    chk("R4 first", gpr_waddr, 3);
    drive(1'b1, PL, FM, 12, 0, 1'b0, 5'd0);
    chk("R4 second vector", vr_we, 1);
    chk("R4 second addr", vr_waddr, 1);
    drive(1'b1, PL, FM, 13, 0, 1'b0, 5'd0);
    chk("R4 third", gpr_waddr, 5);
    drive(1'b1, PL, FM, 14, 0, 1'b0, 5'd0);
    chk("R4 same-cycle push", gpr_waddr, 2);
    chk("R4 fourth we", gpr_we, 1);
    exp_pc += 4;

    push(4);
    drive(1'b1, ST, FM, 7, 0, 1'b0, 5'd0);
    chk("R3 store no write", gpr_we | vr_we, 0);
    drive(1'b1, PL, FR, 55, 0, 1'b0, 5'd0);
    chk("R3 entry kept", gpr_waddr, 4);
    chk("R3 data", gpr_wdata, 55);
    exp_pc += 2;
    drive(1'b1, PL, FJ, 32'hFFFF_FFFF, 0, 1'b0, 5'd0);
    chk("R7 minus one not taken", squash, 0);
    drive(1'b1, JL, FJ, 0, 0, 1'b0, 5'd0);
    chk("R7 zero not taken", squash, 0);
    chk("R7 no link", gpr_we, 0);
    exp_pc += 2;
    idle();
    chk("R9 pc", pc, exp_pc);

    push(6);
    drive(1'b1, NP, FR, 1, 0, 1'b0, 5'd0);
    chk("R2 nop no write", gpr_we, 0);
    drive(1'b1, PL, FI, 1, 0, 1'b0, 5'd0);
    chk("R2 invalid no write", gpr_we | vr_we, 0);
    idle();
    chk("R2 pc held", pc, exp_pc);
    drive(1'b1, PL, FR, 77, 0, 1'b0, 5'd0);
    chk("R2 entry not popped", gpr_waddr, 6);
    chk("R2 data", gpr_wdata, 77);

    push(6); push(7);
    drive(1'b1, PL, FJ, 32'h20, 0, 1'b1, 5'd3);
    chk("R7 squash", squash, 1);
    chk("R7 clear", sb_clear, 1);
    chk("R7 no write", gpr_we, 0);
    idle();
    chk("R7 target", pc, 32'h20);
    drive(1'b1, PL, FR, 9, 0, 1'b0, 5'd0);
    chk("R6 empty pop no write", gpr_we | vr_we, 0);
    idle();
    chk("R6 err set", err, 1);
    push(2);
    drive(1'b1, PL, FR, 9, 0, 1'b0, 5'd0);
    chk("R6 blocked write", gpr_we | vr_we, 0);
    drive(1'b1, PL, FJ, 32'h30, 0, 1'b0, 5'd0);
    chk("R6 blocked jump", squash, 0);
    idle();
    chk("R6 sticky", err, 1);
    chk("R6 pc frozen", pc, 32'h21);

    do_reset();
    drive(1'b1, JL, FJ, 32'h40, 0, 1'b0, 5'd0);
    chk("R8 link we", gpr_we, 1);
    chk("R8 link addr", gpr_waddr, 1);
    chk("R8 link data", gpr_wdata, 17);
    chk("R8 squash", squash, 1);
    idle();
    chk("R8 pc", pc, 32'h40);
    drive(1'b1, PL, FJ, 32'hFF, 0, 1'b0, 5'd0);
    drive(1'b1, ST, FM, 0, 0, 1'b0, 5'd0);
    idle();
    chk("R9 wrap", pc, 0);

    for (int i = 12; i < 32; i++) begin
      do_reset();
      push(i);
      drive(1'b1, PL, FR, 5, 0, 1'b0, 5'd0);
      chk("R6 out of range no write", gpr_we | vr_we, 0);
      idle();
      chk("R6 out of range err", err, 1);
    end

    do_reset();
    for (int i = 1; i <= 5; i++) push(i);
    for (int j = 1; j <= 4; j++) begin
      drive(1'b1, PL, FR, j, 0, 1'b0, 5'd0);
      chk("R10 kept order", gpr_waddr, j);
      chk("R10 kept we", gpr_we, 1);
    end
    drive(1'b1, PL, FR, 0, 0, 1'b0, 5'd0);
    chk("R10 dropped push", gpr_we | vr_we, 0);
    idle();
    chk("R10 empty err", err, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule